// File: doc/BRIEF.md
# Priority ATM Cell Scheduler

This block decides, once per scheduling slot, which channel may send one cell on a shared ATM link. A local tick divided by a programmable count sets the slot length. A circular schedule table of programmable length is stepped once per slot. Together the table length and the slot length fix the range of cell rates the scheduler can give.

Each slot goes first to a constant-bit-rate (CBR) channel, if the current table entry reserves that slot for a ready channel. Otherwise the slot goes to the arbitrated channels. Every channel carries one of eight priorities. The highest priority that has a ready channel wins, and round-robin picks among the ready channels of that priority. The top four priorities can each carry a peak-cell-rate cap: a credit budget that is spent one credit per won slot and refilled once per pass through the table. The result of each slot is one granted channel number, or an idle slot.

Top module: `cell_sched`

## Requirements
- R1: Slot timing. A slot occurs on every (`slot_div_i`+1)-th `tick_i` pulse counted since reset. `slot_o` pulses for exactly one clock, in the cycle after the tick that completes the slot. When `slot_o` is low, `grant_vld_o` and `grant_cbr_o` are low.
- R2: Table index. The first slot after reset uses index 0. Each following slot uses the next index. After index `tbl_len_i`-1 the index returns to 0. The index of each slot is shown on `slot_idx_o` while `slot_o` is high.
- R3: CBR grant. A table entry is written with `cfg_kind_i`=1, where the address is the entry, data bit 4 marks the entry valid and data bits 3:0 give the channel. When the current entry is valid and its channel is ready, that channel is granted with `grant_cbr_o`=1, whatever other channels request.
- R4: CBR fall-through. A valid entry whose channel is not ready hands its slot to priority arbitration.
- R5: CBR-only channels. A channel is configured with `cfg_kind_i`=0, where the address is the channel, data bits 2:0 give its priority and data bit 3 makes it CBR-only. A CBR-only channel never wins through arbitration, although table entries can still grant it.
- R6: Priority order. Priority 7 is the highest. In a slot that no CBR entry takes, the highest eligible priority with a ready channel wins.
- R7: Round-robin. Within one priority, the next grant goes to the next ready channel of that priority above the last winner, wrapping around after channel 15. After reset the search starts at channel 0.
- R8: Peak-rate caps. Only priorities 4 to 7 can be capped. A cap is written with `cfg_kind_i`=2: address bits 1:0 select priority 4+address, data bit 8 enables the cap, and data bits 7:0 give the credit limit. The write also loads the credit with the limit. Each arbitrated win at a capped priority uses one credit. A capped priority with zero credit is skipped, so lower priorities can win.
- R9: Credit refill. At the slot with index `tbl_len_i`-1, after that slot's grant has been taken, every capped priority's credit is reloaded to its limit.
- R10: Idle slot. If no channel is eligible, the slot shows `slot_o`=1 with `grant_vld_o`=0 and `grant_ch_o`=0.
- R11: Reset state. After reset all outputs are 0. Every channel has priority 0 and is not CBR-only, every table entry is invalid, and no cap is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Local timing tick, one cycle per pulse |
| slot_div_i | input | 8 | Ticks per slot minus one |
| tbl_len_i | input | 5 | Number of schedule table entries in use (1..16) |
| ready_i | input | 16 | Per-channel ready request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 2 | 0 channel, 1 table entry, 2 cap |
| cfg_addr_i | input | 4 | Channel, entry or cap selector |
| cfg_data_i | input | 9 | Configuration value |
| slot_o | output | 1 | Slot result valid this cycle |
| grant_vld_o | output | 1 | A channel was granted |
| grant_cbr_o | output | 1 | Grant came from a table entry |
| grant_ch_o | output | 4 | Granted channel |
| slot_idx_o | output | 4 | Table index of this slot |

## Verification
A stale round-robin pointer shows up as a channel winning twice in a row while a peer of the same priority waits, and this is visible on the next slot of that priority. A wrong credit count becomes visible within one table pass: a capped priority either takes more slots than its limit between refills, or loses slots it still had credit for. A slip in the tick divider or the table index moves `slot_o` or `slot_idx_o` on the very next slot. The reference model tracks pointers, credits and the index independently, so every such fault shows in the cycle it first reaches an output.

// File: rtl/cell_sched_pkg.sv
package cell_sched_pkg;
  typedef enum logic [1:0] {
    CFG_CHAN = 2'd0,
    CFG_TBL  = 2'd1,
    CFG_CAP  = 2'd2
  } cfg_kind_e;
endpackage

// File: rtl/cs_slot_timer.sv
module cs_slot_timer #(
  parameter int DIV_W = 8,
  parameter int TBL_W = 4,
  parameter int LEN_W = TBL_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             fire_o,
  output logic             wrap_o,
  output logic [TBL_W-1:0] idx_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [TBL_W-1:0] idx_q;
  logic             last;

  assign fire_o = tick_i && (cnt_q == div_i);
  assign last   = ({1'b0, idx_q} + LEN_W'(1)) >= len_i;
  assign wrap_o = fire_o && last;
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (fire_o) begin
      cnt_q <= '0;
      idx_q <= last ? '0 : idx_q + 1'b1;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cs_cfg_store.sv
module cs_cfg_store #(
  parameter int NUM_CH    = 16,
  parameter int TBL_DEPTH = 16,
  parameter int PRIO_W    = 3,
  parameter int CH_W      = 4,
  parameter int TBL_W     = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             chan_we_i,
  input  logic                             tbl_we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [PRIO_W:0]                  chan_data_i,
  input  logic [CH_W:0]                    tbl_data_i,
  input  logic [TBL_W-1:0]                 rd_idx_i,
  output logic [NUM_CH-1:0][PRIO_W-1:0]    prio_o,
  output logic [NUM_CH-1:0]                only_o,
  output logic                             cbr_vld_o,
  output logic [CH_W-1:0]                  cbr_ch_o
);
  logic [TBL_DEPTH-1:0]           tv_q;
  logic [TBL_DEPTH-1:0][CH_W-1:0] tc_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_o[c] <= '0;
        only_o[c] <= 1'b0;
      end else if (chan_we_i && addr_i == ADDR_W'(c)) begin
        prio_o[c] <= chan_data_i[PRIO_W-1:0];
        only_o[c] <= chan_data_i[PRIO_W];
      end
    end
  end

  for (genvar t = 0; t < TBL_DEPTH; t++) begin : g_tbl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tv_q[t] <= 1'b0;
        tc_q[t] <= '0;
      end else if (tbl_we_i && addr_i == ADDR_W'(t)) begin
        tv_q[t] <= tbl_data_i[CH_W];
        tc_q[t] <= tbl_data_i[CH_W-1:0];
      end
    end
  end

  assign cbr_vld_o = tv_q[rd_idx_i];
  assign cbr_ch_o  = tc_q[rd_idx_i];
endmodule

// File: rtl/cs_credit_bank.sv
module cs_credit_bank #(
  parameter int NUM_PRIO = 8,
  parameter int NUM_CAP  = 4,
  parameter int CRED_W   = 8,
  parameter int PRIO_W   = 3,
  parameter int ADDR_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CRED_W:0]     data_i,
  input  logic                use_i,
  input  logic [PRIO_W-1:0]   use_prio_i,
  input  logic                refill_i,
  output logic [NUM_PRIO-1:0] elig_o
);
  localparam int CAP_BASE = NUM_PRIO - NUM_CAP;

  for (genvar p = 0; p < NUM_PRIO; p++) begin : g_prio
    if (p < CAP_BASE) begin : g_free
      assign elig_o[p] = 1'b1;
    end else begin : g_cap
      logic              en_q;
      logic [CRED_W-1:0] lim_q;
      logic [CRED_W-1:0] cred_q;
      logic              sel;
      assign sel = cap_we_i && (addr_i == ADDR_W'(p - CAP_BASE));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          en_q   <= 1'b0;
          lim_q  <= '0;
          cred_q <= '0;
        end else if (sel) begin
          en_q   <= data_i[CRED_W];
          lim_q  <= data_i[CRED_W-1:0];
          cred_q <= data_i[CRED_W-1:0];
        end else if (refill_i) begin
          cred_q <= lim_q;
        end else if (use_i && use_prio_i == PRIO_W'(p) && en_q && cred_q != '0) begin
          cred_q <= cred_q - 1'b1;
        end
      end

      assign elig_o[p] = !en_q || (cred_q != '0);
    end
  end
endmodule

// File: rtl/cs_prio_arb.sv
module cs_prio_arb #(
  parameter int NUM_CH   = 16,
  parameter int NUM_PRIO = 8,
  parameter int CH_W     = 4,
  parameter int PRIO_W   = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CH-1:0]             req_i,
  input  logic [NUM_CH-1:0][PRIO_W-1:0] prio_i,
  input  logic [NUM_PRIO-1:0]           elig_i,
  input  logic                          upd_i,
  output logic                          vld_o,
  output logic [CH_W-1:0]               ch_o,
  output logic [PRIO_W-1:0]             prio_o
);
  logic [NUM_PRIO-1:0][CH_W-1:0] rr_q;
  logic [NUM_PRIO-1:0][CH_W-1:0] cand_ch;
  logic [NUM_PRIO-1:0]           cand_ok;

  // per priority: first requester after the last winner
  always_comb begin
    int c;
    for (int p = 0; p < NUM_PRIO; p++) begin
      cand_ok[p] = 1'b0;
      cand_ch[p] = '0;
      for (int off = NUM_CH; off >= 1; off--) begin
        c = (int'(rr_q[p]) + off) % NUM_CH;
        if (req_i[c] && prio_i[c] == PRIO_W'(p)) begin
          cand_ok[p] = 1'b1;
          cand_ch[p] = CH_W'(c);
        end
      end
    end
  end

  always_comb begin
    vld_o  = 1'b0;
    ch_o   = '0;
    prio_o = '0;
    for (int p = 0; p < NUM_PRIO; p++) begin
      if (cand_ok[p] && elig_i[p]) begin
        vld_o  = 1'b1;
        ch_o   = cand_ch[p];
        prio_o = PRIO_W'(p);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PRIO; p++) rr_q[p] <= CH_W'(NUM_CH - 1);
    end else if (upd_i && vld_o) begin
      rr_q[prio_o] <= ch_o;
    end
  end
endmodule

// File: rtl/cell_sched.sv
module cell_sched
  import cell_sched_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int TBL_DEPTH = 16,
  parameter int NUM_PRIO  = 8,
  parameter int NUM_CAP   = 4,
  parameter int CRED_W    = 8,
  parameter int DIV_W     = 8,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int TBL_W    = $clog2(TBL_DEPTH),
  localparam int LEN_W    = TBL_W + 1,
  localparam int PRIO_W   = $clog2(NUM_PRIO),
  localparam int ADDR_W   = (CH_W > TBL_W) ? CH_W : TBL_W,
  localparam int DW0      = (CH_W > PRIO_W) ? CH_W + 1 : PRIO_W + 1,
  localparam int DATA_W   = (CRED_W + 1 > DW0) ? CRED_W + 1 : DW0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DIV_W-1:0]  slot_div_i,
  input  logic [LEN_W-1:0]  tbl_len_i,
  input  logic [NUM_CH-1:0] ready_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_kind_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  output logic              slot_o,
  output logic              grant_vld_o,
  output logic              grant_cbr_o,
  output logic [CH_W-1:0]   grant_ch_o,
  output logic [TBL_W-1:0]  slot_idx_o
);
  logic                          fire, wrap;
  logic [TBL_W-1:0]              idx;
  logic [NUM_CH-1:0][PRIO_W-1:0] prio;
  logic [NUM_CH-1:0]             only;
  logic                          cbr_vld, cbr_hit;
  logic [CH_W-1:0]               cbr_ch;
  logic [NUM_PRIO-1:0]           elig;
  logic                          arb_vld;
  logic [CH_W-1:0]               arb_ch;
  logic [PRIO_W-1:0]             arb_prio;
  logic                          chan_we, tbl_we, cap_we;

  assign chan_we = cfg_we_i && (cfg_kind_i == CFG_CHAN);
  assign tbl_we  = cfg_we_i && (cfg_kind_i == CFG_TBL);
  assign cap_we  = cfg_we_i && (cfg_kind_i == CFG_CAP);

  cs_slot_timer #(.DIV_W(DIV_W), .TBL_W(TBL_W), .LEN_W(LEN_W)) u_timer (
    .clk_i, .rst_ni, .tick_i,
    .div_i(slot_div_i), .len_i(tbl_len_i),
    .fire_o(fire), .wrap_o(wrap), .idx_o(idx)
  );

  cs_cfg_store #(
    .NUM_CH(NUM_CH), .TBL_DEPTH(TBL_DEPTH), .PRIO_W(PRIO_W),
    .CH_W(CH_W), .TBL_W(TBL_W), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .chan_we_i(chan_we), .tbl_we_i(tbl_we), .addr_i(cfg_addr_i),
    .chan_data_i(cfg_data_i[PRIO_W:0]), .tbl_data_i(cfg_data_i[CH_W:0]),
    .rd_idx_i(idx), .prio_o(prio), .only_o(only),
    .cbr_vld_o(cbr_vld), .cbr_ch_o(cbr_ch)
  );

  assign cbr_hit = cbr_vld && ready_i[cbr_ch];

  cs_prio_arb #(.NUM_CH(NUM_CH), .NUM_PRIO(NUM_PRIO), .CH_W(CH_W), .PRIO_W(PRIO_W)) u_arb (
    .clk_i, .rst_ni,
    .req_i(ready_i & ~only), .prio_i(prio), .elig_i(elig),
    .upd_i(fire && !cbr_hit),
    .vld_o(arb_vld), .ch_o(arb_ch), .prio_o(arb_prio)
  );

  cs_credit_bank #(
    .NUM_PRIO(NUM_PRIO), .NUM_CAP(NUM_CAP), .CRED_W(CRED_W),
    .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
  ) u_cred (
    .clk_i, .rst_ni,
    .cap_we_i(cap_we), .addr_i(cfg_addr_i), .data_i(cfg_data_i[CRED_W:0]),
    .use_i(fire && !cbr_hit && arb_vld), .use_prio_i(arb_prio),
    .refill_i(wrap), .elig_o(elig)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o      <= 1'b0;
      grant_vld_o <= 1'b0;
      grant_cbr_o <= 1'b0;
      grant_ch_o  <= '0;
      slot_idx_o  <= '0;
    end else begin
      slot_o      <= fire;
      grant_vld_o <= fire && (cbr_hit || arb_vld);
      grant_cbr_o <= fire && cbr_hit;
      grant_ch_o  <= !fire ? '0 : (cbr_hit ? cbr_ch : (arb_vld ? arb_ch : '0));
      slot_idx_o  <= fire ? idx : '0;
    end
  end
endmodule

// File: rtl/cell_sched_chk.sv
module cell_sched_chk #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int TBL_W  = 4,
  parameter int LEN_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [LEN_W-1:0]  tbl_len_i,
  input logic [NUM_CH-1:0] ready_i,
  input logic              slot_o,
  input logic              grant_vld_o,
  input logic              grant_cbr_o,
  input logic [CH_W-1:0]   grant_ch_o,
  input logic [TBL_W-1:0]  slot_idx_o
);
  logic [NUM_CH-1:0] rdy_q;
  logic              seen_q;
  logic [TBL_W-1:0]  last_q, nxt;

  assign nxt = (({1'b0, last_q} + LEN_W'(1)) >= tbl_len_i) ? '0 : last_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= '0;
      seen_q <= 1'b0;
      last_q <= '0;
    end else begin
      rdy_q <= ready_i;
      if (slot_o) begin
        seen_q <= 1'b1;
        last_q <= slot_idx_o;
      end
    end
  end

  AST_SLOT_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o |-> $past(tick_i)); // R1
  AST_QUIET_OFF_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_o |-> (!grant_vld_o && !grant_cbr_o)); // R1
  AST_FIRST_IDX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o && !seen_q) |-> (slot_idx_o == '0)); // R2
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o && seen_q) |-> (slot_idx_o == nxt)); // R2
  AST_CBR_IS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_cbr_o |-> grant_vld_o); // R3
  AST_GRANT_WAS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> rdy_q[grant_ch_o]); // R6
  AST_IDLE_NO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o && rdy_q == '0) |-> (!grant_vld_o && grant_ch_o == '0)); // R10
endmodule

bind cell_sched cell_sched_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .TBL_W(TBL_W), .LEN_W(LEN_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .tbl_len_i(tbl_len_i),
  .ready_i(ready_i), .slot_o(slot_o), .grant_vld_o(grant_vld_o),
  .grant_cbr_o(grant_cbr_o), .grant_ch_o(grant_ch_o), .slot_idx_o(slot_idx_o)
);

// File: tb/cell_sched_test.sv
module cell_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [7:0]  slot_div_i = '0;
  logic [4:0]  tbl_len_i = 5'd4;
  logic [15:0] ready_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_kind_i = '0;
  logic [3:0]  cfg_addr_i = '0;
  logic [8:0]  cfg_data_i = '0;
  logic        slot_o, grant_vld_o, grant_cbr_o;
  logic [3:0]  grant_ch_o, slot_idx_o;

  always #5 clk = ~clk;

  cell_sched uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .slot_div_i(slot_div_i),
    .tbl_len_i(tbl_len_i), .ready_i(ready_i), .cfg_we_i(cfg_we_i),
    .cfg_kind_i(cfg_kind_i), .cfg_addr_i(cfg_addr_i), .cfg_data_i(cfg_data_i),
    .slot_o(slot_o), .grant_vld_o(grant_vld_o), .grant_cbr_o(grant_cbr_o),
    .grant_ch_o(grant_ch_o), .slot_idx_o(slot_idx_o)
  );

  int    n_cmp = 0, n_bad = 0, cyc = 0, tcount = 0, tick_gap = 0;
  bit    done = 0;
  string phase = "R11";

  // reference model state
  int m_cnt, m_idx;
  int m_prio[16], m_only[16], m_tv[16], m_tc[16], m_rr[8];
  int m_en[8], m_lim[8], m_cred[8];
  bit e_slot, e_vld, e_cbr;
  int e_ch, e_idx;

  function automatic bit prio_ok(int p);
    return (p < 4) || (m_en[p] == 0) || (m_cred[p] > 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_idx = 0;
      for (int i = 0; i < 16; i++) begin m_prio[i] = 0; m_only[i] = 0; m_tv[i] = 0; m_tc[i] = 0; end
      for (int p = 0; p < 8; p++) begin m_rr[p] = 15; m_en[p] = 0; m_lim[p] = 0; m_cred[p] = 0; end
      e_slot = 0; e_vld = 0; e_cbr = 0; e_ch = 0; e_idx = 0;
    end else begin
      e_slot = 0; e_vld = 0; e_cbr = 0; e_ch = 0; e_idx = 0;
      if (tick_i && m_cnt == int'(slot_div_i)) begin
        int win;
        win = -1;
        e_slot = 1; e_idx = m_idx;
        if (m_tv[m_idx] != 0 && ready_i[m_tc[m_idx]]) begin
          win = m_tc[m_idx]; e_cbr = 1;
        end else begin
          for (int p = 7; p >= 0; p--) begin
            if (win < 0 && prio_ok(p)) begin
              for (int off = 1; off <= 16; off++) begin
                int c;
                c = (m_rr[p] + off) % 16;
                if (win < 0 && ready_i[c] && m_only[c] == 0 && m_prio[c] == p) win = c;
              end
              if (win >= 0) begin
                m_rr[p] = win;
                if (p >= 4 && m_en[p] != 0 && m_cred[p] > 0) m_cred[p]--;
              end
            end
          end
        end
        if (win >= 0) begin e_vld = 1; e_ch = win; end
        if (m_idx + 1 >= int'(tbl_len_i)) begin
          m_idx = 0;
          for (int p = 4; p < 8; p++) m_cred[p] = m_lim[p];
        end else m_idx++;
        m_cnt = 0;
      end else if (tick_i) m_cnt = (m_cnt + 1) % 256;
      if (cfg_we_i) begin
        case (cfg_kind_i)
          2'd0: begin m_prio[cfg_addr_i] = cfg_data_i[2:0]; m_only[cfg_addr_i] = cfg_data_i[3]; end
          2'd1: begin m_tv[cfg_addr_i] = cfg_data_i[4]; m_tc[cfg_addr_i] = cfg_data_i[3:0]; end
          2'd2: begin
            m_en[4 + cfg_addr_i[1:0]]   = cfg_data_i[8];
            m_lim[4 + cfg_addr_i[1:0]]  = cfg_data_i[7:0];
            m_cred[4 + cfg_addr_i[1:0]] = cfg_data_i[7:0];
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (slot_o !== e_slot || grant_vld_o !== e_vld || grant_cbr_o !== e_cbr ||
          grant_ch_o !== 4'(e_ch) || slot_idx_o !== 4'(e_idx)) begin
        n_bad++;
        $display("FAIL %s t=%0t got slot=%b vld=%b cbr=%b ch=%0d idx=%0d exp slot=%b vld=%b cbr=%b ch=%0d idx=%0d",
                 phase, $time, slot_o, grant_vld_o, grant_cbr_o, grant_ch_o, slot_idx_o,
                 e_slot, e_vld, e_cbr, e_ch, e_idx);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic do_reset(int len, int div);
    @(negedge clk); #1;
    rst_n = 0; tbl_len_i = 5'(len); slot_div_i = 8'(div);
    ready_i = '0; cfg_we_i = 0; tick_i = 0; tcount = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk); #1;
      tick_i = (tick_gap != 0) && (tcount % tick_gap == 0);
      tcount++;
    end
  endtask

  task automatic cfg(int kind, int addr, int data);
    @(negedge clk); #1;
    tick_i = 0; cfg_we_i = 1;
    cfg_kind_i = 2'(kind); cfg_addr_i = 4'(addr); cfg_data_i = 9'(data);
    @(negedge clk); #1;
    cfg_we_i = 0;
  endtask

  initial begin
    // R11: reset values, no ticks
    phase = "R11"; do_reset(4, 0); tick_gap = 0; run(3);
    // R10: every slot idle
    phase = "R10"; tick_gap = 1; run(6);
    cfg(0, 2, 9'h003); cfg(0, 5, 9'h006); cfg(0, 9, 9'h006); cfg(0, 12, 9'h006); cfg(0, 1, 9'h000);
    // R6: higher priority beats lower
    phase = "R6"; ready_i = 16'h0006; run(4);
    ready_i = 16'h0026; run(4);
    // R7: rotation among priority 6 channels 5, 9, 12
    phase = "R7"; ready_i = 16'h1226; run(10);
    // R5: channel 9 becomes CBR-only
    phase = "R5"; cfg(0, 9, 9'h00E); run(8);
    // R3: entries 1 and 3 reserve channels 7 and 9
    phase = "R3"; cfg(1, 1, 9'h017); cfg(1, 3, 9'h019); ready_i = 16'h12A6; run(10);
    // R4: reserved channels not ready
    phase = "R4"; ready_i = 16'h1026; run(10);
    // R1: divider 2, ticks every cycle then every third cycle
    phase = "R1"; do_reset(3, 2); tick_gap = 1;
    cfg(0, 1, 9'h002); ready_i = 16'h0002; run(12);
    tick_gap = 3; run(24);
    // R8: prio 7 capped at 1 per pass, prio 5 capped at 0
    phase = "R8"; tick_gap = 1;
    cfg(0, 4, 9'h007); cfg(0, 6, 9'h005);
    cfg(2, 3, 9'h101); cfg(2, 1, 9'h100);
    ready_i = 16'h0052; run(30);
    // R9: refill each pass, prio 5 raised to 2 per pass
    phase = "R9"; cfg(2, 1, 9'h102); run(40);
    // R2: full-length table wrap
    phase = "R2"; do_reset(16, 0); tick_gap = 1; ready_i = 16'h0001; run(40);
    tbl_len_i = 5'd16; run(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule